// File: doc/BRIEF.md
# Interrupt Pin Service and Acknowledge Engine

This block tracks interrupt requests arriving on a bank of input pins and turns each serviced request into one memory-write style interrupt message: a 32-bit address and a 32-bit data word, offered on a valid/ready handshake. Each pin has a routing entry driven in from outside: trigger kind (edge or level), mask, vector, delivery code, a 16-bit destination and a destination-mode bit. The engine owns a pending bit and a remote-acknowledge bit for every pin.

Requests arrive as single-cycle events naming a line number and a level. Edge pins latch a pending request only while unmasked, and the request is consumed when its message is built. Level pins follow the line level and, once serviced, stay quiet until an end-of-interrupt carrying their vector clears the remote-acknowledge bit. A delivery code of external-interrupt makes the engine fetch the vector from a neighbouring controller through a request/acknowledge port before the message leaves.

Top module: `irq_route_engine`

## Requirements
- R1: An event on line 0 acts on pin 2; any other line L acts on pin L when L is below NPIN, and lines at or above NPIN change nothing and produce no message.
- R2: An event with level 1 on an unmasked edge pin produces exactly one message, and the pin produces no further message without a new event.
- R3: An event with level 1 on a masked edge pin is discarded: no message follows, not even after the mask is later removed.
- R4: An event with level 1 on a level pin marks it pending; an unmasked pending level pin with remote acknowledge clear produces exactly one message and then sets remote acknowledge, after which it produces no message while remote acknowledge stays set.
- R5: An event with level 0 on a level pin clears its pending request; a level pin raised while masked keeps its request and is serviced once the mask is removed.
- R6: An end-of-interrupt with vector V clears remote acknowledge on every pin whose entry vector equals V; a cleared pin that is still pending and unmasked is serviced again, and an end-of-interrupt with any other vector has no effect.
- R7: When several pins are eligible, the lowest-numbered one is serviced first.
- R8: The message address is 0xFEE00000 with the pin's destination in bits 19:4 and its destination-mode bit in bit 2, other bits zero.
- R9: The message data holds the vector in bits 7:0, the delivery code in bits 10:8 and the trigger bit (1 = level) in bit 15, other bits zero.
- R10: For delivery code 3'b111 the engine raises ext_req and holds it until ext_ack; the message then carries ext_vec as its vector; for all other codes the vector is the entry's 8-bit vector.
- R11: At most one message is outstanding; while msg_valid is high and msg_ready low, msg_valid, msg_addr and msg_data hold steady, and no vector fetch is in progress.
- R12: An end-of-interrupt accepted while a message is outstanding or a fetch is in progress is held (eoi_ready low) and applied once the engine is idle.
- R13: After reset msg_valid and ext_req are low, eoi_ready is high, and no pin is pending or acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request event strobe |
| in_line | input | LINE_W | Line number of the event |
| in_level | input | 1 | Level carried by the event |
| cfg_mask | input | NPIN | Per-pin mask |
| cfg_level | input | NPIN | Per-pin trigger kind, 1 = level |
| cfg_logical | input | NPIN | Per-pin destination-mode bit |
| cfg_vec | input | NPIN*8 | Per-pin vector, pin i at [8i+7:8i] |
| cfg_dlv | input | NPIN*3 | Per-pin delivery code, pin i at [3i+2:3i] |
| cfg_dest | input | NPIN*16 | Per-pin destination, pin i at [16i+15:16i] |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_ready | output | 1 | End-of-interrupt can be taken |
| eoi_vec | input | 8 | End-of-interrupt vector |
| ext_req | output | 1 | Vector fetch request to the external controller |
| ext_ack | input | 1 | Fetch response strobe |
| ext_vec | input | 8 | Fetched vector |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench builds the engine with NPIN=8 and LINE_W=4, so that every line number, including the eight out-of-range ones, can be swept in a single pass and each one's message compared with an address and data word computed from the pin number. The small pin count also keeps the pin 0 to pin 2 redirection, fixed-priority ordering, masked edge and level behaviour, queued end-of-interrupt and the vector fetch each within a few dozen cycles of a directed scenario.

// File: rtl/irq_route_engine.sv
module irq_route_engine #(
  parameter int NPIN   = 24,
  parameter int LINE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [LINE_W-1:0]    in_line,
  input  logic                 in_level,
  input  logic [NPIN-1:0]      cfg_mask,
  input  logic [NPIN-1:0]      cfg_level,
  input  logic [NPIN-1:0]      cfg_logical,
  input  logic [NPIN*8-1:0]    cfg_vec,
  input  logic [NPIN*3-1:0]    cfg_dlv,
  input  logic [NPIN*16-1:0]   cfg_dest,
  input  logic                 eoi_valid,
  output logic                 eoi_ready,
  input  logic [7:0]           eoi_vec,
  output logic                 ext_req,
  input  logic                 ext_ack,
  input  logic [7:0]           ext_vec,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [31:0]          msg_addr,
  output logic [31:0]          msg_data
);
  localparam int        PW       = (NPIN > 1) ? $clog2(NPIN) : 1;
  localparam logic [2:0] DLV_EXT = 3'b111;
  localparam logic [31:0] BASE   = 32'hFEE0_0000;

  logic [NPIN-1:0] pend, ack;
  logic            fetching;
  logic            eoi_q_valid;
  logic [7:0]      eoi_q_vec;

  logic [LINE_W-1:0] pin_l;
  logic              hit;
  logic [NPIN-1:0]   in_hot;
  assign pin_l  = (in_line == '0) ? LINE_W'(2) : in_line;
  assign hit    = in_valid && (int'(pin_l) < NPIN);
  assign in_hot = hit ? (NPIN'(1) << pin_l) : '0;

  logic [NPIN-1:0] lvl_set, lvl_clr, edg_set;
  assign lvl_set = in_hot & cfg_level & {NPIN{in_level}};
  assign lvl_clr = in_hot & cfg_level & {NPIN{~in_level}};
  assign edg_set = in_hot & ~cfg_level & ~cfg_mask & {NPIN{in_level}};

  logic [NPIN-1:0] elig;
  assign elig = pend & ~cfg_mask & ~(cfg_level & ack);

  logic          sel_any;
  logic [PW-1:0] sel_idx;
  always_comb begin
    sel_any = 1'b0;
    sel_idx = '0;
    for (int i = NPIN - 1; i >= 0; i--) begin
      if (elig[i]) begin
        sel_any = 1'b1;
        sel_idx = PW'(i);
      end
    end
  end

  logic busy, take;
  assign busy = msg_valid | fetching;
  assign take = !busy && sel_any;

  logic [NPIN-1:0] take_hot;
  assign take_hot = take ? (NPIN'(1) << sel_idx) : '0;

  logic [7:0]  sel_vec;
  logic [2:0]  sel_dlv;
  logic [15:0] sel_dest;
  logic        sel_lvl, sel_log;
  assign sel_vec  = cfg_vec[sel_idx*8 +: 8];
  assign sel_dlv  = cfg_dlv[sel_idx*3 +: 3];
  assign sel_dest = cfg_dest[sel_idx*16 +: 16];
  assign sel_lvl  = cfg_level[sel_idx];
  assign sel_log  = cfg_logical[sel_idx];

  logic [31:0] addr_new, data_new;
  assign addr_new = BASE | (32'(sel_dest) << 4) | (32'(sel_log) << 2);
  assign data_new = {16'd0, sel_lvl, 4'd0, sel_dlv, sel_vec};

  logic            eoi_do;
  logic [7:0]      eoi_use;
  logic [NPIN-1:0] eoi_clr;
  assign eoi_ready = !eoi_q_valid;
  assign eoi_use   = eoi_q_valid ? eoi_q_vec : eoi_vec;
  assign eoi_do    = !busy && (eoi_q_valid || eoi_valid);

  always_comb begin
    for (int i = 0; i < NPIN; i++)
      eoi_clr[i] = eoi_do && ack[i] && (cfg_vec[i*8 +: 8] == eoi_use);
  end

  assign ext_req = fetching;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend        <= '0;
      ack         <= '0;
      fetching    <= 1'b0;
      msg_valid   <= 1'b0;
      msg_addr    <= '0;
      msg_data    <= '0;
      eoi_q_valid <= 1'b0;
      eoi_q_vec   <= '0;
    end else begin
      pend <= ((pend & ~(take_hot & ~cfg_level)) & ~lvl_clr) | lvl_set | edg_set;
      ack  <= (ack & ~eoi_clr) | (take_hot & cfg_level);

      if (eoi_q_valid) begin
        if (!busy) eoi_q_valid <= 1'b0;
      end else if (eoi_valid && busy) begin
        eoi_q_valid <= 1'b1;
        eoi_q_vec   <= eoi_vec;
      end

      if (msg_valid && msg_ready) msg_valid <= 1'b0;

      if (fetching && ext_ack) begin
        fetching      <= 1'b0;
        msg_valid     <= 1'b1;
        msg_data[7:0] <= ext_vec;
      end

      if (take) begin
        msg_addr <= addr_new;
        msg_data <= data_new;
        if (sel_dlv == DLV_EXT) fetching  <= 1'b1;
        else                    msg_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_route_engine_chk.sv
module irq_route_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [31:0] msg_addr,
  input logic [31:0] msg_data,
  input logic        ext_req,
  input logic        ext_ack,
  input logic        eoi_valid,
  input logic        eoi_ready
);
  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R11

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_valid && ext_req)); // R11

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> ext_req); // R10

  AST_ADDR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[31:20] == 12'hFEE && msg_addr[3] == 1'b0 && msg_addr[1:0] == 2'b00)); // R8

  AST_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_data[31:16] == 16'd0 && msg_data[14:11] == 4'd0)); // R9

  AST_EOI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_ready && msg_valid) |=> !eoi_ready); // R12
endmodule

bind irq_route_engine irq_route_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data),
  .ext_req(ext_req), .ext_ack(ext_ack),
  .eoi_valid(eoi_valid), .eoi_ready(eoi_ready)
);

// File: tb/irq_route_engine_bench.sv
`timescale 1ns/1ps
module irq_route_engine_bench;
  localparam int NP = 8;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          in_valid = 0, in_level = 0;
  logic [LW-1:0] in_line = '0;
  logic [NP-1:0] mask = '0, lvl = '0, logi = '0;
  logic [NP*8-1:0]  vec = '0;
  logic [NP*3-1:0]  dlv = '0;
  logic [NP*16-1:0] dest = '0;
  logic          eoi_valid = 0;
  logic [7:0]    eoi_vec = '0;
  logic          eoi_ready, ext_req;
  logic          ext_ack = 0;
  logic [7:0]    ext_vec = '0;
  logic          msg_valid;
  logic          msg_ready = 1;
  logic [31:0]   msg_addr, msg_data;

  irq_route_engine #(.NPIN(NP), .LINE_W(LW)) u_irq_route_engine (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_line(in_line), .in_level(in_level),
    .cfg_mask(mask), .cfg_level(lvl), .cfg_logical(logi),
    .cfg_vec(vec), .cfg_dlv(dlv), .cfg_dest(dest),
    .eoi_valid(eoi_valid), .eoi_ready(eoi_ready), .eoi_vec(eoi_vec),
    .ext_req(ext_req), .ext_ack(ext_ack), .ext_vec(ext_vec),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int checks = 0, failures = 0;
  int nmsg = 0;
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];

  always @(negedge clk) begin
    #1;
    if (rst_n && msg_valid && msg_ready) begin
      log_addr[nmsg % 64] = msg_addr;
      log_data[nmsg % 64] = msg_data;
      nmsg++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_line(input int l, input bit level);
    @(negedge clk);
    in_valid = 1; in_line = LW'(l); in_level = level;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send_eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1; eoi_vec = v;
    @(negedge clk);
    eoi_valid = 0;
  endtask

  function automatic logic [31:0] exp_addr(input int p);
    return 32'hFEE0_0000 | ((32'h1230 + 32'(p)) << 4) | (32'(p & 1) << 2);
  endfunction

  function automatic logic [31:0] exp_data(input logic [7:0] v, input logic [2:0] d, input bit l);
    return 32'(v) | (32'(d) << 8) | (32'(l) << 15);
  endfunction

  function automatic logic [31:0] last_data();
    return log_data[(nmsg - 1) % 64];
  endfunction

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=done", wd);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int n0;
    for (int p = 0; p < NP; p++) begin
      vec[p*8 +: 8]   = 8'h40 + 8'(p);
      dest[p*16 +: 16] = 16'h1230 + 16'(p);
      logi[p]         = p[0];
    end
    tick(3);
    check(!msg_valid, "R13 msg_valid after reset", 32'(msg_valid), 0);
    check(!ext_req, "R13 ext_req after reset", 32'(ext_req), 0);
    check(eoi_ready, "R13 eoi_ready after reset", 32'(eoi_ready), 1);
    rst_n = 1;
    tick(5);
    check(nmsg == 0, "R13 no message from idle pins", 32'(nmsg), 0);

    // R1 R2 R8 R9: sweep every line number on edge pins
    for (int l = 0; l < 16; l++) begin
      int p;
      p = (l == 0) ? 2 : l;
      n0 = nmsg;
      send_line(l, 1);
      tick(8);
      if (p < NP) begin
        check(nmsg == n0 + 1, "R2 one message per edge", 32'(nmsg - n0), 1);
        check(log_addr[(nmsg-1)%64] == exp_addr(p), "R8 address", log_addr[(nmsg-1)%64], exp_addr(p));
        check(last_data() == exp_data(8'h40 + 8'(p), 3'd0, 0), "R9 data", last_data(),
              exp_data(8'h40 + 8'(p), 3'd0, 0));
      end else begin
        check(nmsg == n0, "R1 out-of-range line ignored", 32'(nmsg - n0), 0);
      end
    end

    // R3: masked edge dropped
    mask[5] = 1;
    n0 = nmsg;
    send_line(5, 1);
    tick(8);
    check(nmsg == n0, "R3 masked edge no message", 32'(nmsg - n0), 0);
    mask[5] = 0;
    tick(8);
    check(nmsg == n0, "R3 masked edge not latched", 32'(nmsg - n0), 0);

    // R4 R6: level pin 3
    lvl[3] = 1; vec[3*8 +: 8] = 8'h73;
    n0 = nmsg;
    send_line(3, 1);
    tick(8);
    check(nmsg == n0 + 1, "R4 level first message", 32'(nmsg - n0), 1);
    check(last_data() == exp_data(8'h73, 3'd0, 1), "R9 level data", last_data(), exp_data(8'h73, 3'd0, 1));
    tick(20);
    check(nmsg == n0 + 1, "R4 no repeat while acknowledged", 32'(nmsg - n0), 1);
    send_eoi(8'h55);
    tick(8);
    check(nmsg == n0 + 1, "R6 mismatched eoi ignored", 32'(nmsg - n0), 1);
    send_eoi(8'h73);
    tick(8);
    check(nmsg == n0 + 2, "R6 matching eoi reservices", 32'(nmsg - n0), 2);

    // R12 R11: eoi held while a message is outstanding
    msg_ready = 0;
    send_line(6, 1);
    tick(4);
    check(msg_valid == 1, "R11 message held", 32'(msg_valid), 1);
    check(msg_data[7:0] == 8'h46, "R11 held data", 32'(msg_data[7:0]), 32'h46);
    n0 = nmsg;
    @(negedge clk);
    eoi_valid = 1; eoi_vec = 8'h73;
    @(negedge clk);
    eoi_valid = 0;
    check(eoi_ready == 0, "R12 eoi held while busy", 32'(eoi_ready), 0);
    check(nmsg == n0, "R11 nothing accepted while not ready", 32'(nmsg - n0), 0);
    msg_ready = 1;
    tick(10);
    check(nmsg == n0 + 2, "R12 held eoi applied after message", 32'(nmsg - n0), 2);
    check(last_data() == exp_data(8'h73, 3'd0, 1), "R12 pin 3 reserviced", last_data(), exp_data(8'h73, 3'd0, 1));
    check(eoi_ready == 1, "R12 eoi_ready back", 32'(eoi_ready), 1);

    // R5: low level clears pending
    send_line(3, 0);
    send_eoi(8'h73);
    n0 = nmsg;
    tick(8);
    check(nmsg == n0, "R5 low level cleared request", 32'(nmsg - n0), 0);

    // R5: masked level kept, serviced on unmask
    lvl[4] = 1; mask[4] = 1;
    send_line(4, 1);
    tick(8);
    check(nmsg == n0, "R5 masked level silent", 32'(nmsg - n0), 0);
    mask[4] = 0;
    tick(8);
    check(nmsg == n0 + 1, "R5 level serviced after unmask", 32'(nmsg - n0), 1);
    check(last_data() == exp_data(8'h44, 3'd0, 1), "R5 level data", last_data(), exp_data(8'h44, 3'd0, 1));

    // R7: lowest pin first
    msg_ready = 0;
    send_line(6, 1);
    tick(3);
    send_line(1, 1);
    send_line(4, 0);
    send_line(5, 1);
    tick(2);
    n0 = nmsg;
    msg_ready = 1;
    tick(14);
    check(nmsg == n0 + 3, "R7 three messages", 32'(nmsg - n0), 3);
    check(log_data[n0 % 64][7:0] == 8'h46, "R7 outstanding first", 32'(log_data[n0 % 64][7:0]), 32'h46);
    check(log_data[(n0+1) % 64][7:0] == 8'h41, "R7 pin 1 next", 32'(log_data[(n0+1) % 64][7:0]), 32'h41);
    check(log_data[(n0+2) % 64][7:0] == 8'h45, "R7 pin 5 last", 32'(log_data[(n0+2) % 64][7:0]), 32'h45);

    // R10: external vector fetch
    dlv[7*3 +: 3] = 3'b111;
    n0 = nmsg;
    send_line(7, 1);
    for (int k = 0; k < 10 && !ext_req; k++) tick(1);
    check(ext_req == 1, "R10 fetch requested", 32'(ext_req), 1);
    tick(3);
    check(ext_req == 1 && msg_valid == 0, "R10 fetch held, no message", {30'd0, ext_req, msg_valid}, 32'h2);
    @(negedge clk);
    ext_ack = 1; ext_vec = 8'hA5;
    @(negedge clk);
    ext_ack = 0;
    tick(6);
    check(nmsg == n0 + 1, "R10 one fetched message", 32'(nmsg - n0), 1);
    check(last_data() == exp_data(8'hA5, 3'b111, 0), "R10 fetched vector", last_data(), exp_data(8'hA5, 3'b111, 0));
    check(log_addr[(nmsg-1)%64] == exp_addr(7), "R10 address", log_addr[(nmsg-1)%64], exp_addr(7));
    check(ext_req == 0, "R10 fetch released", 32'(ext_req), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule